// File: doc/BRIEF.md
# Prescaled Reloading Event Counter

This block is a pair of counters paced by a slow tick enable. An internal divider turns the system clock into a one-cycle tick pulse at a rate set by parameters. On each tick, a down-counter moves toward zero. When the down-counter is already zero on a tick, it reloads from a programmable reload register, and an up-running event counter advances on that same tick. As a result, zero stays visible for one whole tick period before the reload.

If the reload value is zero, the down-counter stays at zero. From then on, the event counter advances on every tick. This makes the block a plain tick counter.

Software writes each of the three registers through its own enable and data port. A write replaces the tick update of that register for that cycle. The bus decode that drives these ports sits in a separate register block.

Top module: `prescale_event_counter`

## Requirements
- R1: After reset, the reload register, the down-counter and the event counter all read zero.
- R2: `tickPulse` is high for exactly one system-clock cycle out of every SYS_CLK_HZ/TICK_HZ cycles. Outside those cycles the counters change only through writes.
- R3: On a tick, a nonzero down-counter decreases by exactly one and the event counter is unchanged. With no tick and no write, both counters hold their values.
- R4: On a tick where the down-counter is zero, it takes the reload value and the event counter increases by one in the same cycle. With reload 5 and start 7, successive ticks show 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event counter rises on the two ticks that show 5 after a 0.
- R5: With a reload value of zero, a down-counter that reaches zero stays at zero, and the event counter increases by one on every tick.
- R6: The event counter wraps from 0xFFFFFFFF to 0 on its next increment.
- R7: A write to any one register in a tick cycle stores the written value in place of that register's tick update. The other registers still take their normal tick update, which is decided by the down-counter value from before the write.
- R8: Writing the reload register leaves the current down-counter value unchanged. The new value is used at the next reload event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadWrEn | input | 1 | Write strobe for the reload register |
| reloadWrData | input | 32 | Value written to the reload register |
| downWrEn | input | 1 | Write strobe for the down-counter |
| downWrData | input | 32 | Value written to the down-counter |
| eventWrEn | input | 1 | Write strobe for the event counter |
| eventWrData | input | 32 | Value written to the event counter |
| tickPulse | output | 1 | One-cycle prescale tick enable |
| reloadVal | output | 32 | Current reload register |
| downCount | output | 32 | Current down-counter |
| eventCount | output | 32 | Current event counter |

## Verification
The main sweep tries every pairing of reload values 0 to 4 with start values 0 to 5, over run lengths of 1 to 12 ticks. Each case is compared with a closed-form model: a period of reload+1 ticks, entered after the start value has run out. Reload zero separates the stick-at-zero rule from ordinary reloading. Start values below, equal to and above the reload value expose any off-by-one in where the first reload lands. Runs ending just before and just after a reload tell a decrement from a reload.

Directed cases cover the remaining rules:
- A write timed to land on a tick with the down-counter at zero shows that the write wins over the tick update, while the untouched counters still update.
- A reload write made mid-count shows that the change is deferred to the next reload.
- A preset all-ones event counter checks the wrap.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic wrReload;   // load reload register from its write port
    logic wrDown;     // load down-counter from its write port
    logic wrEvent;    // load event counter from its write port
    logic decDown;    // tick with nonzero down-counter: decrement
    logic reloadDown; // tick with zero down-counter: take reload value
    logic incEvent;   // tick with zero down-counter: count an event
  } ctrlStrobes_t;

endpackage

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
#(
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int TICK_HZ    = 20_000_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reloadWrEn,
  input  logic         downWrEn,
  input  logic         eventWrEn,
  input  logic         downIsZero,
  output ctrlStrobes_t strobes,
  output logic         tickPulse
);

  localparam int DIV_RATIO = (SYS_CLK_HZ / TICK_HZ < 1) ? 1 : SYS_CLK_HZ / TICK_HZ;
  localparam int DIV_W     = (DIV_RATIO < 2) ? 1 : $clog2(DIV_RATIO);

  generate
    if (DIV_RATIO == 1) begin : g_noDiv
      assign tickPulse = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      logic [DIV_W-1:0] divLast;
      assign divLast   = DIV_W'(DIV_RATIO - 1);
      assign tickPulse = (divCnt == divLast);

      always_ff @(posedge clk) begin
        if (!rstN)          divCnt <= '0;
        else if (tickPulse) divCnt <= '0;
        else                divCnt <= divCnt + 1'b1;
      end

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        tickPulse |=> !tickPulse);
      // R2
      div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        divCnt <= divLast);
    end
  endgenerate

  always_comb begin
    strobes            = '0;
    strobes.wrReload   = reloadWrEn;
    strobes.wrDown     = downWrEn;
    strobes.wrEvent    = eventWrEn;
    strobes.decDown    = tickPulse && !downIsZero && !downWrEn;
    strobes.reloadDown = tickPulse &&  downIsZero && !downWrEn;
    strobes.incEvent   = tickPulse &&  downIsZero && !eventWrEn;
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDown, strobes.decDown, strobes.reloadDown}));

endmodule

// File: rtl/evtcnt_dpath.sv
module evtcnt_dpath
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic [CNT_W-1:0] downWrData,
  input  logic [CNT_W-1:0] eventWrData,
  output logic             downIsZero,
  output logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] downCount,
  output logic [CNT_W-1:0] eventCount
);

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] downReg;
  logic [CNT_W-1:0] eventReg;

  assign downIsZero = (downReg == '0);
  assign reloadVal  = reloadReg;
  assign downCount  = downReg;
  assign eventCount = eventReg;

  always_ff @(posedge clk) begin
    if (!rstN)                 reloadReg <= '0;
    else if (strobes.wrReload) reloadReg <= reloadWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   downReg <= '0;
    else if (strobes.wrDown)     downReg <= downWrData;
    else if (strobes.reloadDown) downReg <= reloadReg;
    else if (strobes.decDown)    downReg <= downReg - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 eventReg <= '0;
    else if (strobes.wrEvent)  eventReg <= eventWrData;
    else if (strobes.incEvent) eventReg <= eventReg + 1'b1;
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decDown |=> downReg == $past(downReg) - 1'b1);
  // R4
  reload_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reloadDown |=> downReg == $past(reloadReg));
  // R4
  event_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incEvent |=> eventReg == $past(eventReg) + 1'b1);
  // R7
  down_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDown |=> downReg == $past(downWrData));
  // R3
  down_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrDown || strobes.decDown || strobes.reloadDown) |=> $stable(downReg));
  // R8
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrReload |=> $stable(reloadReg));

endmodule

// File: rtl/prescale_event_counter.sv
module prescale_event_counter
  import evtcnt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int TICK_HZ    = 20_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             downWrEn,
  input  logic [CNT_W-1:0] downWrData,
  input  logic             eventWrEn,
  input  logic [CNT_W-1:0] eventWrData,
  output logic             tickPulse,
  output logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] downCount,
  output logic [CNT_W-1:0] eventCount
);

  ctrlStrobes_t strobes;
  logic         downIsZero;

  evtcnt_ctrl #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .TICK_HZ   (TICK_HZ)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reloadWrEn(reloadWrEn),
    .downWrEn  (downWrEn),
    .eventWrEn (eventWrEn),
    .downIsZero(downIsZero),
    .strobes   (strobes),
    .tickPulse (tickPulse)
  );

  evtcnt_dpath #(
    .CNT_W(CNT_W)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reloadWrData(reloadWrData),
    .downWrData  (downWrData),
    .eventWrData (eventWrData),
    .downIsZero  (downIsZero),
    .reloadVal   (reloadVal),
    .downCount   (downCount),
    .eventCount  (eventCount)
  );

endmodule

// File: tb/sim_prescale_event_counter.sv
`timescale 1ns/1ps
module sim_prescale_event_counter;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reloadWrEn = 1'b0, downWrEn = 1'b0, eventWrEn = 1'b0;
  logic [31:0] reloadWrData = '0, downWrData = '0, eventWrData = '0;
  logic        tickPulse;
  logic [31:0] reloadVal, downCount, eventCount;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prescale_event_counter #(
    .CNT_W(32), .SYS_CLK_HZ(200_000_000), .TICK_HZ(50_000_000)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .downWrEn(downWrEn), .downWrData(downWrData),
    .eventWrEn(eventWrEn), .eventWrData(eventWrData),
    .tickPulse(tickPulse), .reloadVal(reloadVal),
    .downCount(downCount), .eventCount(eventCount)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; drives a write for one posedge; returns whether a tick hit it
  task automatic writeRegs(input bit wR, input logic [31:0] dR,
                           input bit wD, input logic [31:0] dD,
                           input bit wE, input logic [31:0] dE, output bit tickHit);
    reloadWrEn = wR; reloadWrData = dR;
    downWrEn   = wD; downWrData   = dD;
    eventWrEn  = wE; eventWrData  = dE;
    tickHit = tickPulse;
    @(negedge clk);
    reloadWrEn = 1'b0; downWrEn = 1'b0; eventWrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    int k = 0;
    while (k < n) begin
      if (tickPulse) k++;
      @(negedge clk);
    end
  endtask

  task automatic waitTick();
    while (!tickPulse) @(negedge clk);
  endtask

  // Closed-form model: start s, reload r, k ticks
  function automatic void model(input int s, input int r, input int k,
                                output int d, output int ev);
    int y;
    if (k < s) begin
      d = s - k; ev = 0;
    end else begin
      y = k - s + r;
      d = r - (y % (r + 1));
      ev = y / (r + 1);
    end
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    bit th;
    int d, ev, pos0, pos1, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "reload", reloadVal, 32'd0);
    check("R1", "down", downCount, 32'd0);
    check("R1", "event", eventCount, 32'd0);

    // R2 tick spacing
    waitTick(); pos0 = 0; cnt = 0;
    @(negedge clk); pos1 = 1;
    while (!tickPulse) begin pos1++; @(negedge clk); end
    check("R2", "tick period", pos1, DIV);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin if (tickPulse) cnt++; @(negedge clk); end
    check("R2", "ticks in 40 cycles", cnt, 40 / DIV);

    // R3 hold between ticks: down and event stay put on non-tick cycles
    writeRegs(1, 32'd2, 1, 32'd9, 1, 32'd4, th);
    while (tickPulse) @(negedge clk);
    check("R3", "down held off-tick", downCount, 32'd9);
    check("R3", "event held off-tick", eventCount, 32'd4);

    // R3 R4 R5 sweep against closed-form model
    for (int r = 0; r <= 4; r++)
      for (int s = 0; s <= 5; s++)
        for (int k = 1; k <= 12; k++) begin
          writeRegs(1, 32'(r), 1, 32'(s), 1, 32'd0, th);
          runTicks(k);
          model(s, r, k, d, ev);
          check(r == 0 ? "R5" : (k <= s ? "R3" : "R4"), "down", downCount, 32'(d));
          check(r == 0 ? "R5" : "R4", "event", eventCount, 32'(ev));
        end

    // R4 documented sequence, reload 5 start 7
    writeRegs(1, 32'd5, 1, 32'd7, 1, 32'd0, th);
    for (int k = 1; k <= 14; k++) begin
      runTicks(1);
      model(7, 5, k, d, ev);
      check("R4", "seq down", downCount, 32'(d));
      check("R4", "seq event", eventCount, 32'(ev));
    end

    // R6 wrap
    writeRegs(1, 32'd3, 1, 32'd0, 1, 32'hFFFF_FFFF, th);
    runTicks(1);
    check("R6", "event wrap", eventCount, 32'd0);
    check("R6", "down reload", downCount, 32'd3);

    // R7 event write wins on a reload tick; down still reloads
    writeRegs(1, 32'd7, 1, 32'd0, 1, 32'd10, th);
    waitTick();
    writeRegs(0, 0, 0, 0, 1, 32'd100, th);
    check("R7", "event written", eventCount, 32'd100);
    check("R7", "down reloaded", downCount, 32'd7);
    // R7 down write wins on a tick; event untouched
    waitTick();
    writeRegs(0, 0, 1, 32'd20, 0, 0, th);
    check("R7", "down written", downCount, 32'd20);
    check("R7", "event after down write", eventCount, 32'd100);
    // R7 down write on zero-down tick: event still counts
    writeRegs(0, 0, 1, 32'd0, 0, 0, th);
    waitTick();
    writeRegs(0, 0, 1, 32'd50, 0, 0, th);
    check("R7", "down written at zero", downCount, 32'd50);
    check("R7", "event counts with down write", eventCount, 32'd101);

    // R8 reload write does not touch down; used at next reload
    writeRegs(1, 32'd2, 1, 32'd3, 1, 32'd0, th);
    writeRegs(1, 32'd6, 0, 0, 0, 0, th);
    check("R8", "down unchanged by reload write", downCount, th ? 32'd2 : 32'd3);
    check("R8", "reload stored", reloadVal, 32'd6);
    runTicks(th ? 3 : 4);
    check("R8", "new reload used", downCount, 32'd6);
    check("R8", "event at reload", eventCount, 32'd1);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule